// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block sits beside a bus master and judges every access it makes against a table of programmable protection regions. Each region is a naturally aligned power-of-two window of at least 32 bytes. It is cut into eight equal slices, and any slice can be dropped from the region on its own. A region carries an access-permission code and an execute-never flag. For each access presented on the access port (address, read or write, instruction fetch, privilege level, fault-handler flag), the block returns a permit or fault verdict in the same cycle, with no register in that path.

Software sets up the table through a five-entry register window. A selector register picks the region that the base and size words read and write. The size word packs the region enable, the encoded size, the slice disable mask and the attribute bits. A read-only identity word reports how many regions exist and that instructions and data share one map. A control word turns checking on and off, lets privileged code reach unmapped addresses, and decides whether checking stays active while a fault handler runs. The region count is a parameter and must be 8 or 16.

Top module: `mem_prot_unit`

## Requirements
- R1: Register offset 0 is the identity word. It reads NUM_REGIONS in bits [15:8] and zero in every other bit, so bit 0 = 0 marks a shared instruction/data map. Writes to it have no effect.
- R2: Offset 1 is the control word: bit 0 enables checking, bit 1 keeps checking active during fault handling, bit 2 enables the privileged default map. While bit 0 is clear, every access is permitted.
- R3: Offset 2 selects a region by its low log2(NUM_REGIONS) bits and reads back as that index. Base (offset 3) and size (offset 4) accesses go only to the selected region.
- R4: The size word reads back all 32 written bits. Bit 0 is the enable, [5:1] holds log2(size) minus 1, [15:8] is the slice disable mask, [31:16] holds the attributes. The base word stores bits [31:5], and bits [4:0] read as zero.
- R5: A region matches when it is enabled, its size field is at least 4 (32 bytes), and the address bits at and above log2(size) equal the base. Base bits below the size are ignored. A field below 4 or a clear enable never matches.
- R6: Slice k of a region (address bits [n-1:n-3] = k for a 2^n region) is excluded when mask bit k is 1. The mask is ignored for regions smaller than 256 bytes.
- R7: When several regions match, the highest-numbered one decides. An excluded slice falls through to lower regions.
- R8: An access that matches no region faults, unless it is privileged and control bit 2 is set.
- R9: The permission code in size-word bits [26:24] works as follows: 0 and 4 deny all access; 1 allows privileged read/write only; 2 allows privileged read/write and unprivileged read; 3 allows read/write at both levels; 5 allows privileged read only; 6 and 7 allow reads at both levels. Fetches count as reads.
- R10: Size-word bit 28 is execute-never. A fetch that hits such a region faults, while reads still follow R9.
- R11: While the fault-handler input is high and control bit 1 is clear, every access is permitted. With bit 1 set, the normal checks apply.
- R12: After reset the control word, the selector and every region's base and size read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgAddr | input | 3 | Register offset (0 identity, 1 control, 2 select, 3 base, 4 size) |
| cfgWrite | input | 1 | Write strobe, takes effect at the clock edge |
| cfgWdata | input | 32 | Write data |
| cfgRdata | output | 32 | Read data for cfgAddr, combinational |
| accAddr | input | 32 | Address of the access under test |
| accWrite | input | 1 | 1 for a write, 0 for a read or fetch |
| accFetch | input | 1 | 1 for an instruction fetch |
| accPriv | input | 1 | 1 when the access is privileged |
| accHardFault | input | 1 | 1 while a fault handler is running |
| accPermit | output | 1 | 1 permits the access, 0 signals a fault; combinational |

## Verification
A corrupted region word does not show up until an access lands in that region or the word is read back through the selector. The bench therefore reads every word it writes and probes addresses on both sides of each size and slice boundary. A wrong priority order between regions only shows where regions overlap, so the bench layers a no-access region and a read/write region over a wide base region and probes the shared window. The verdict is combinational, so a wrong control or region state shows on accPermit during the cycle right after the register write that set it.

// File: rtl/prot_pkg.sv
`timescale 1ns/1ps
package prot_pkg;

  typedef enum logic [2:0] {
    CFG_TYPE = 3'd0,
    CFG_CTRL = 3'd1,
    CFG_SEL  = 3'd2,
    CFG_BASE = 3'd3,
    CFG_SIZE = 3'd4
  } cfg_reg_e;

  // bit 2 privileged default map, bit 1 check during fault handler, bit 0 enable
  typedef struct packed {
    logic privDef;
    logic hfEn;
    logic en;
  } ctrl_t;

  // strobes from the register control to the region datapath
  typedef struct packed {
    logic wrBase;
    logic wrSize;
  } strobe_t;

  localparam int SIZE_EN_BIT  = 0;
  localparam int SIZE_FLD_LO  = 1;
  localparam int SUB_MASK_LO  = 8;
  localparam int PERM_LO      = 24;
  localparam int XN_BIT       = 28;
  localparam int MIN_SIZE_FLD = 4;   // 32-byte region
  localparam int SUB_MIN_LOG2 = 8;   // slices honoured from 256 bytes up
  localparam int BASE_LO      = 5;

  function automatic logic permAllows(input logic [2:0] perm, input logic priv,
                                      input logic wr);
    case (perm)
      3'd1:    return priv;
      3'd2:    return priv || !wr;
      3'd3:    return 1'b1;
      3'd5:    return priv && !wr;
      3'd6,
      3'd7:    return !wr;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/prot_region_match.sv
`timescale 1ns/1ps
module prot_region_match
  import prot_pkg::*;
(
  input  logic [31:BASE_LO] base,
  input  logic              regionEn,
  input  logic [4:0]        sizeFld,
  input  logic [7:0]        subMask,
  input  logic [31:0]       addr,
  output logic              hit
);

  logic [5:0]        log2Size;
  logic              sizeOk;
  logic [31:BASE_LO] cmpMask;
  logic              baseMatch;
  logic [5:0]        subShift;
  logic [31:0]       shifted;
  logic [2:0]        subIdx;
  logic              subOff;

  always_comb begin
    log2Size = {1'b0, sizeFld} + 6'd1;
    sizeOk   = int'(sizeFld) >= MIN_SIZE_FLD;
    for (int i = BASE_LO; i < 32; i++) begin
      cmpMask[i] = (i >= int'(log2Size));
    end
    baseMatch = ((addr[31:BASE_LO] ^ base) & cmpMask) == '0;
    subShift  = log2Size - 6'd3;
    shifted   = addr >> subShift;
    subIdx    = shifted[2:0];
    subOff    = (int'(log2Size) >= SUB_MIN_LOG2) && subMask[subIdx];
    hit       = regionEn && sizeOk && baseMatch && !subOff;
  end

endmodule

// File: rtl/prot_ctrl.sv
`timescale 1ns/1ps
module prot_ctrl
  import prot_pkg::*;
#(
  parameter  int NUM_REGIONS = 8,
  localparam int SEL_W       = $clog2(NUM_REGIONS),
  localparam int LOW_W       = (SEL_W > 3) ? SEL_W : 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cfgAddr,
  input  logic             cfgWrite,
  input  logic [31:0]      cfgWdata,
  input  logic [31:0]      selBase,
  input  logic [31:0]      selSize,
  output ctrl_t            ctrlState,
  output logic [SEL_W-1:0] selIdx,
  output strobe_t          strobe,
  output logic [31:0]      cfgRdata
);

  localparam logic [31:0] TYPE_WORD = {16'd0, 8'(NUM_REGIONS), 8'd0};

  logic unusedWdataHi;
  assign unusedWdataHi = ^cfgWdata[31:LOW_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlState <= '0;
      selIdx    <= '0;
    end else if (cfgWrite) begin
      if (cfgAddr == CFG_CTRL) ctrlState <= ctrl_t'(cfgWdata[2:0]);
      if (cfgAddr == CFG_SEL)  selIdx    <= cfgWdata[SEL_W-1:0];
    end
  end

  always_comb begin
    strobe.wrBase = cfgWrite && (cfgAddr == CFG_BASE);
    strobe.wrSize = cfgWrite && (cfgAddr == CFG_SIZE);
  end

  always_comb begin
    case (cfgAddr)
      CFG_TYPE: cfgRdata = TYPE_WORD;
      CFG_CTRL: cfgRdata = {29'd0, ctrlState};
      CFG_SEL:  cfgRdata = 32'(selIdx);
      CFG_BASE: cfgRdata = selBase;
      CFG_SIZE: cfgRdata = selSize;
      default:  cfgRdata = '0;
    endcase
  end

endmodule

// File: rtl/prot_datapath.sv
`timescale 1ns/1ps
module prot_datapath
  import prot_pkg::*;
#(
  parameter  int NUM_REGIONS = 8,
  localparam int SEL_W       = $clog2(NUM_REGIONS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [SEL_W-1:0] selIdx,
  input  logic [31:0]      cfgWdata,
  input  ctrl_t            ctrlState,
  output logic [31:0]      selBase,
  output logic [31:0]      selSize,
  input  logic [31:0]      accAddr,
  input  logic             accWrite,
  input  logic             accFetch,
  input  logic             accPriv,
  input  logic             accHardFault,
  output logic             hitAny,
  output logic             hitXn,
  output logic             accPermit
);

  logic [31:BASE_LO] baseMem [NUM_REGIONS];
  logic [31:0]       sizeMem [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] hitVec;
  logic [SEL_W-1:0]  hitIdx;
  logic [2:0]        hitPerm;
  logic              bypass;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        baseMem[r] <= '0;
        sizeMem[r] <= '0;
      end
    end else begin
      if (strobe.wrBase) baseMem[selIdx] <= cfgWdata[31:BASE_LO];
      if (strobe.wrSize) sizeMem[selIdx] <= cfgWdata;
    end
  end

  assign selBase = {baseMem[selIdx], {BASE_LO{1'b0}}};
  assign selSize = sizeMem[selIdx];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    prot_region_match u_match (
      .base     (baseMem[g]),
      .regionEn (sizeMem[g][SIZE_EN_BIT]),
      .sizeFld  (sizeMem[g][SIZE_FLD_LO +: 5]),
      .subMask  (sizeMem[g][SUB_MASK_LO +: 8]),
      .addr     (accAddr),
      .hit      (hitVec[g])
    );
  end

  // ascending scan: the last (highest-numbered) hit wins
  always_comb begin
    hitAny = 1'b0;
    hitIdx = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hitVec[i]) begin
        hitAny = 1'b1;
        hitIdx = SEL_W'(i);
      end
    end
    hitXn   = hitAny && sizeMem[hitIdx][XN_BIT];
    hitPerm = sizeMem[hitIdx][PERM_LO +: 3];
  end

  always_comb begin
    bypass = !ctrlState.en || (accHardFault && !ctrlState.hfEn);
    if (bypass)
      accPermit = 1'b1;
    else if (!hitAny)
      accPermit = accPriv && ctrlState.privDef;
    else
      accPermit = !(accFetch && hitXn) && permAllows(hitPerm, accPriv, accWrite);
  end

endmodule

// File: rtl/mem_prot_unit.sv
`timescale 1ns/1ps
module mem_prot_unit
  import prot_pkg::*;
#(
  parameter  int NUM_REGIONS = 8,
  localparam int SEL_W       = $clog2(NUM_REGIONS)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  cfgAddr,
  input  logic        cfgWrite,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  input  logic [31:0] accAddr,
  input  logic        accWrite,
  input  logic        accFetch,
  input  logic        accPriv,
  input  logic        accHardFault,
  output logic        accPermit
);

  ctrl_t            ctrlState;
  strobe_t          strobe;
  logic [SEL_W-1:0] selIdx;
  logic [31:0]      selBase;
  logic [31:0]      selSize;
  logic             hitAny;
  logic             hitXn;

  prot_ctrl #(.NUM_REGIONS(NUM_REGIONS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgAddr   (cfgAddr),
    .cfgWrite  (cfgWrite),
    .cfgWdata  (cfgWdata),
    .selBase   (selBase),
    .selSize   (selSize),
    .ctrlState (ctrlState),
    .selIdx    (selIdx),
    .strobe    (strobe),
    .cfgRdata  (cfgRdata)
  );

  prot_datapath #(.NUM_REGIONS(NUM_REGIONS)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .selIdx       (selIdx),
    .cfgWdata     (cfgWdata),
    .ctrlState    (ctrlState),
    .selBase      (selBase),
    .selSize      (selSize),
    .accAddr      (accAddr),
    .accWrite     (accWrite),
    .accFetch     (accFetch),
    .accPriv      (accPriv),
    .accHardFault (accHardFault),
    .hitAny       (hitAny),
    .hitXn        (hitXn),
    .accPermit    (accPermit)
  );

endmodule

// File: rtl/mem_prot_unit_chk.sv
`timescale 1ns/1ps
module mem_prot_unit_chk #(
  parameter  int NUM_REGIONS = 8,
  localparam int SEL_W       = $clog2(NUM_REGIONS),
  localparam int LOW_W       = (SEL_W > 3) ? SEL_W : 3
) (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  cfgAddr,
  input logic        cfgWrite,
  input logic [31:0] cfgWdata,
  input logic [31:0] cfgRdata,
  input logic        accFetch,
  input logic        accPriv,
  input logic        accHardFault,
  input logic        accPermit,
  input logic        hitAny,
  input logic        hitXn
);

  logic [2:0]       shCtrl;
  logic [SEL_W-1:0] shSel;
  logic             checking;
  logic             unusedWdataHi;

  assign unusedWdataHi = ^cfgWdata[31:LOW_W];
  assign checking = shCtrl[0] && !(accHardFault && !shCtrl[1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shCtrl <= '0;
      shSel  <= '0;
    end else if (cfgWrite) begin
      if (cfgAddr == 3'd1) shCtrl <= cfgWdata[2:0];
      if (cfgAddr == 3'd2) shSel  <= cfgWdata[SEL_W-1:0];
    end
  end

  a_r1_type_word: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr == 3'd0) |-> (cfgRdata == {16'd0, 8'(NUM_REGIONS), 8'd0}));

  a_r2_off_permits: assert property (@(posedge clk) disable iff (!rstN)
    !shCtrl[0] |-> accPermit);

  a_r3_sel_readback: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr == 3'd2) |-> (cfgRdata == 32'(shSel)));

  a_r8_unmapped_user_faults: assert property (@(posedge clk) disable iff (!rstN)
    (checking && !hitAny && !accPriv) |-> !accPermit);

  a_r10_xn_fetch_faults: assert property (@(posedge clk) disable iff (!rstN)
    (checking && hitAny && hitXn && accFetch) |-> !accPermit);

  a_r11_handler_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (accHardFault && !shCtrl[1]) |-> accPermit);

endmodule

bind mem_prot_unit mem_prot_unit_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgAddr      (cfgAddr),
  .cfgWrite     (cfgWrite),
  .cfgWdata     (cfgWdata),
  .cfgRdata     (cfgRdata),
  .accFetch     (accFetch),
  .accPriv      (accPriv),
  .accHardFault (accHardFault),
  .accPermit    (accPermit),
  .hitAny       (hitAny),
  .hitXn        (hitXn)
);

// File: tb/mem_prot_unit_test.sv
`timescale 1ns/1ps
module mem_prot_unit_test;

  localparam int NREG = 8;
  localparam logic [2:0] A_TYPE = 3'd0, A_CTRL = 3'd1, A_SEL = 3'd2,
                         A_BASE = 3'd3, A_SIZE = 3'd4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic        cfgWrite = 1'b0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic [31:0] accAddr = '0;
  logic        accWrite = 1'b0;
  logic        accFetch = 1'b0;
  logic        accPriv = 1'b0;
  logic        accHardFault = 1'b0;
  logic        accPermit;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mem_prot_unit #(.NUM_REGIONS(NREG)) uut (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWrite(cfgWrite),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .accAddr(accAddr),
    .accWrite(accWrite), .accFetch(accFetch), .accPriv(accPriv),
    .accHardFault(accHardFault), .accPermit(accPermit)
  );

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic cfgWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgAddr = a; cfgWdata = d; cfgWrite = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic cfgRd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgAddr = a; cfgWrite = 1'b0;
    #2 d = cfgRdata;
  endtask

  task automatic region(input int idx, input logic [31:0] base, input logic [31:0] size);
    cfgWr(A_SEL, 32'(idx));
    cfgWr(A_BASE, base);
    cfgWr(A_SIZE, size);
  endtask

  // wr, fe, pr, hf then expected verdict
  task automatic chkAcc(input string tag, input logic [31:0] a, input logic wr,
                        input logic fe, input logic pr, input logic hf, input logic exp);
    accAddr = a; accWrite = wr; accFetch = fe; accPriv = pr; accHardFault = hf;
    #2 chkEq(tag, 32'(accPermit), 32'(exp));
    accHardFault = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    cfgRd(A_TYPE, d); chkEq("R1 identity word", d, 32'h0000_0800);
    cfgRd(A_CTRL, d); chkEq("R12 control zero", d, 32'h0);
    cfgRd(A_SEL,  d); chkEq("R12 select zero", d, 32'h0);
    cfgRd(A_BASE, d); chkEq("R12 base zero", d, 32'h0);
    cfgRd(A_SIZE, d); chkEq("R12 size zero", d, 32'h0);
    chkAcc("R2 off permits user write", 32'h9000_0000, 1, 0, 0, 0, 1);
  endtask

  task automatic testReadback();
    logic [31:0] d;
    cfgWr(A_TYPE, 32'hFFFF_FFFF);
    cfgRd(A_TYPE, d); chkEq("R1 identity write ignored", d, 32'h0000_0800);
    region(3, 32'h2000_001F, 32'hABCD_5AD7);
    cfgRd(A_SEL,  d); chkEq("R3 select readback", d, 32'd3);
    cfgRd(A_BASE, d); chkEq("R4 base low bits zero", d, 32'h2000_0000);
    cfgRd(A_SIZE, d); chkEq("R4 size word readback", d, 32'hABCD_5AD7);
    cfgWr(A_SEL, 32'd5);
    cfgRd(A_BASE, d); chkEq("R3 other region untouched base", d, 32'h0);
    cfgRd(A_SIZE, d); chkEq("R3 other region untouched size", d, 32'h0);
    cfgWr(A_SEL, 32'd3);
    cfgRd(A_BASE, d); chkEq("R3 reselect base", d, 32'h2000_0000);
    cfgWr(A_SIZE, 32'h0);
  endtask

  task automatic testBasic();
    logic [31:0] d;
    cfgWr(A_CTRL, 32'h1);
    cfgRd(A_CTRL, d); chkEq("R2 control readback", d, 32'h1);
    region(0, 32'h0000_1000, 32'h0300_0017);          // 4 KiB, code 3
    chkAcc("R5 inside 4K user read", 32'h0000_1800, 0, 0, 0, 0, 1);
    chkAcc("R5 top of 4K user write", 32'h0000_1FFC, 1, 0, 0, 0, 1);
    chkAcc("R8 unmapped user faults", 32'h0000_2000, 0, 0, 0, 0, 0);
    chkAcc("R8 unmapped priv faults without default", 32'h0000_2000, 0, 0, 1, 0, 0);
    cfgWr(A_CTRL, 32'h5);
    chkAcc("R8 unmapped priv with default", 32'h0000_2000, 1, 0, 1, 0, 1);
    chkAcc("R8 unmapped user with default", 32'h0000_2000, 0, 0, 0, 0, 0);
    cfgWr(A_CTRL, 32'h1);
    region(2, 32'h0000_8040, 32'h0300_000F);          // 256 B, base low bits ignored
    chkAcc("R5 base below size ignored", 32'h0000_8000, 0, 0, 0, 0, 1);
    chkAcc("R5 just past region", 32'h0000_8100, 0, 0, 0, 0, 0);
    cfgWr(A_SIZE, 32'h0300_0007);                     // 16 B field: illegal
    chkAcc("R5 size below 32B never matches", 32'h0000_8000, 0, 0, 0, 0, 0);
    cfgWr(A_SIZE, 32'h0300_000E);                     // enable clear
    chkAcc("R5 disabled region no match", 32'h0000_8000, 0, 0, 0, 0, 0);
  endtask

  task automatic testSlices();
    region(2, 32'h0000_8000, 32'h0300_040F);          // 256 B, slice 2 off
    chkAcc("R6 slice2 excluded", 32'h0000_8040, 0, 0, 0, 0, 0);
    chkAcc("R6 slice1 kept", 32'h0000_8020, 0, 0, 0, 0, 1);
    chkAcc("R6 slice3 kept", 32'h0000_8060, 0, 0, 0, 0, 1);
    cfgWr(A_SIZE, 32'h0300_FF0D);                     // 128 B, mask ignored
    chkAcc("R6 mask ignored 128B low", 32'h0000_8000, 0, 0, 0, 0, 1);
    chkAcc("R6 mask ignored 128B high", 32'h0000_8070, 0, 0, 0, 0, 1);
  endtask

  task automatic testOverlap();
    region(4, 32'h0000_1400, 32'h0000_0013);          // 1 KiB, no access
    chkAcc("R7 higher no-access wins", 32'h0000_1400, 0, 0, 1, 0, 0);
    chkAcc("R7 lower region outside overlap", 32'h0000_1000, 0, 0, 0, 0, 1);
    region(6, 32'h0000_1400, 32'h0300_000F);          // 256 B, read/write
    chkAcc("R7 highest region permits", 32'h0000_1400, 1, 0, 0, 0, 1);
    chkAcc("R7 middle region outside top", 32'h0000_1500, 0, 0, 0, 0, 0);
    cfgWr(A_SIZE, 32'h0300_010F);                     // slice 0 off
    chkAcc("R7 excluded slice falls through", 32'h0000_1400, 0, 0, 0, 0, 0);
    chkAcc("R7 kept slice of top region", 32'h0000_1420, 0, 0, 0, 0, 1);
  endtask

  task automatic testPerm();
    region(7, 32'h0000_4000, 32'h0500_0013);          // code 5
    chkAcc("R9 code5 priv read", 32'h0000_4000, 0, 0, 1, 0, 1);
    chkAcc("R9 code5 priv write", 32'h0000_4000, 1, 0, 1, 0, 0);
    chkAcc("R9 code5 user read", 32'h0000_4000, 0, 0, 0, 0, 0);
    cfgWr(A_SIZE, 32'h0100_0013);
    chkAcc("R9 code1 priv write", 32'h0000_4000, 1, 0, 1, 0, 1);
    chkAcc("R9 code1 user read", 32'h0000_4000, 0, 0, 0, 0, 0);
    cfgWr(A_SIZE, 32'h0200_0013);
    chkAcc("R9 code2 user read", 32'h0000_4000, 0, 0, 0, 0, 1);
    chkAcc("R9 code2 user write", 32'h0000_4000, 1, 0, 0, 0, 0);
    cfgWr(A_SIZE, 32'h0600_0013);
    chkAcc("R9 code6 user read", 32'h0000_4000, 0, 0, 0, 0, 1);
    chkAcc("R9 code6 priv write", 32'h0000_4000, 1, 0, 1, 0, 0);
    cfgWr(A_SIZE, 32'h0000_0013);
    chkAcc("R9 code0 priv read", 32'h0000_4000, 0, 0, 1, 0, 0);
  endtask

  task automatic testXn();
    region(7, 32'h0000_4000, 32'h1300_0013);
    chkAcc("R10 fetch from xn faults", 32'h0000_4010, 0, 1, 1, 0, 0);
    chkAcc("R10 read from xn allowed", 32'h0000_4010, 0, 0, 0, 0, 1);
    cfgWr(A_SIZE, 32'h0300_0013);
    chkAcc("R10 fetch without xn", 32'h0000_4010, 0, 1, 0, 0, 1);
  endtask

  task automatic testHandler();
    cfgWr(A_CTRL, 32'h1);
    chkAcc("R11 handler bypass", 32'h9000_0000, 1, 0, 0, 1, 1);
    cfgWr(A_CTRL, 32'h3);
    chkAcc("R11 handler checked", 32'h9000_0000, 1, 0, 0, 1, 0);
    chkAcc("R11 handler mapped ok", 32'h0000_4000, 0, 0, 0, 1, 1);
    cfgWr(A_CTRL, 32'h0);
    chkAcc("R2 cleared enable permits", 32'h0000_1400, 1, 0, 0, 0, 1);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testReadback();
    testBasic();
    testSlices();
    testOverlap();
    testPerm();
    testXn();
    testHandler();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule